// File: doc/BRIEF.md
# Per-Pixel Correction Coefficient Capture

This block sits in front of the offset subtractor and the gain multiplier of an image sensor processor. It fetches one gain coefficient and one offset coefficient per pixel. It generates the coefficient strobes from its own clock, captures the coefficients, and hands them to the arithmetic stage. Each conversion period lasts `PIX_CYC` cycles of a clock that runs at twice the strobe rate or faster. The rising and falling edges of a strobe are modelled as enables on two chosen cycles of that period, so every flop uses a single clock edge.

Two bus arrangements are supported. In two-bus mode both coefficients arrive on a dedicated coefficient bus, with the gain coefficient in the first half of the period and the offset coefficient in the second half. In one-bus mode the coefficients share the pixel output bus and only the gain strobe is produced. Gain is taken where that strobe rises and offset where it falls. The pixel output enable is withdrawn in exactly those capture cycles, so the pixel driver and the coefficient source never drive the bus together.

Coefficients captured during one period are transferred to the outputs at the end-of-conversion strobe. They then stay on the outputs for the whole next period, which is the period in which the matching pixel leaves the processor.

Top module: `pix_coef_capture`

## Requirements
- R1: A synchronous active-high reset sets the phase counter to 0. It sets the captured and output gain to unity (1 << `GAIN_FRAC`) and the captured and output offset to 0.
- R2: `eoc` is high for exactly one cycle per period. That cycle is the last one of the period (phase `PIX_CYC-1`), and the counter wraps to phase 0 after it.
- R3: `gainStb` is high in phases 0 to `PIX_CYC/2-1` when `cfgIntClk`=1 and `cfgGainEn`=1, and low at all other times.
- R4: `offsStb` is high in phases `PIX_CYC/2` to `PIX_CYC-1` when `cfgIntClk`=1 and `cfgOneBus`=0. It is never high in one-bus mode.
- R5: In two-bus mode (`cfgOneBus`=0) the gain coefficient is sampled from `coefBus` at the edge that ends phase 0. The offset coefficient is sampled from `coefBus` at the edge that ends phase `PIX_CYC/2`.
- R6: In one-bus mode the same two sampling points take their data from `pixBus`, and `coefBus` has no effect on the outputs.
- R7: `pixOe` is 0 exactly in the capture cycles of one-bus mode (phases 0 and `PIX_CYC/2` while `cfgIntClk`=1 and `cfgGainEn`=1), and 1 in all other cycles.
- R8: `gainOut` and `offsOut` change only at the edge that ends an `eoc` cycle. They then carry the coefficients captured in the period that just ended.
- R9: No coefficient is captured while `cfgIntClk`=0. Gain is not captured while `cfgGainEn`=0, and in one-bus mode offset is not captured either. Coefficients that are not captured keep their previous values.
- R10: When an offset capture and the transfer fall in the same cycle (`PIX_CYC`=2), the newly sampled value is the one transferred to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, `PIX_CYC` cycles per conversion |
| rst | input | 1 | Synchronous reset, active high |
| cfgOneBus | input | 1 | 1: coefficients share the pixel bus; 0: separate coefficient bus |
| cfgIntClk | input | 1 | 1: strobes generated internally; 0: no internal capture |
| cfgGainEn | input | 1 | Enables the gain strobe |
| coefBus | input | BUS_W | Dedicated coefficient bus (two-bus mode) |
| pixBus | input | BUS_W | Shared pixel bus as seen on its input side (one-bus mode) |
| gainStb | output | 1 | Gain coefficient strobe |
| offsStb | output | 1 | Offset coefficient strobe (two-bus mode) |
| pixOe | output | 1 | Pixel output driver enable |
| eoc | output | 1 | End-of-conversion strobe |
| gainOut | output | BUS_W | Gain coefficient to the multiplier |
| offsOut | output | BUS_W | Offset coefficient to the subtractor |

## Verification
The bench runs with `PIX_CYC`=2, so each offset capture lands in the same cycle as the end-of-conversion transfer. A naive register chain would forward the previous pixel's offset in that case. The behavioural model applies the capture before the transfer and compares `offsOut` with the freshly sampled bus value on every cycle. Random data changes on both buses every cycle, so a stale or crossed transfer shows up as a value mismatch.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capGain;   // sample gain coefficient this cycle
    logic capOffs;   // sample offset coefficient this cycle
    logic xfer;      // move captured pair to the outputs
    logic selPix;    // take coefficients from the pixel bus
  } strobe_t;

endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl #(
  parameter int PIX_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgOneBus,
  input  logic             cfgIntClk,
  input  logic             cfgGainEn,
  output pcc_pkg::strobe_t stb,
  output logic             gainStb,
  output logic             offsStb,
  output logic             pixOe,
  output logic             eoc
);
  localparam int CW = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PIX_CYC - 1);
  localparam logic [CW-1:0] HALF = CW'(PIX_CYC / 2);

  logic [CW-1:0] phase;
  logic firstHalf, gainRun, offsRun;

  initial begin
    assert (PIX_CYC >= 2 && PIX_CYC % 2 == 0)
      else $error("PIX_CYC must be even and at least 2");
  end

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  always_comb begin
    firstHalf   = (phase < HALF);
    gainRun     = cfgIntClk & cfgGainEn;
    offsRun     = cfgIntClk & (cfgOneBus ? cfgGainEn : 1'b1);
    stb.capGain = gainRun & (phase == '0);
    stb.capOffs = offsRun & (phase == HALF);
    stb.xfer    = (phase == LAST);
    stb.selPix  = cfgOneBus;
    gainStb     = gainRun & firstHalf;
    offsStb     = cfgIntClk & ~cfgOneBus & ~firstHalf;
    pixOe       = ~(cfgOneBus & (stb.capGain | stb.capOffs));
    eoc         = stb.xfer;
  end

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);  // R2
  AST_GAIN_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    stb.capGain |-> gainStb);  // R3
  AST_ONE_BUS_NO_OFFS: assert property (@(posedge clk) disable iff (rst)
    cfgOneBus |-> !offsStb);  // R4
  AST_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    (stb.selPix && (stb.capGain || stb.capOffs)) |-> !pixOe);  // R7
  AST_NO_CAP_EXT: assert property (@(posedge clk) disable iff (rst)
    !cfgIntClk |-> !(stb.capGain || stb.capOffs));  // R9
endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath #(
  parameter int BUS_W     = 10,
  parameter int GAIN_FRAC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pcc_pkg::strobe_t stb,
  input  logic [BUS_W-1:0] coefBus,
  input  logic [BUS_W-1:0] pixBus,
  output logic [BUS_W-1:0] gainOut,
  output logic [BUS_W-1:0] offsOut
);
  localparam logic [BUS_W-1:0] UNITY = BUS_W'(1) << GAIN_FRAC;

  logic [BUS_W-1:0] srcBus, gainCap, offsCap, gainNext, offsNext;

  always_comb begin
    srcBus   = stb.selPix ? pixBus : coefBus;
    gainNext = stb.capGain ? srcBus : gainCap;
    offsNext = stb.capOffs ? srcBus : offsCap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gainCap <= UNITY;
      offsCap <= '0;
      gainOut <= UNITY;
      offsOut <= '0;
    end else begin
      gainCap <= gainNext;
      offsCap <= offsNext;
      if (stb.xfer) begin
        gainOut <= gainNext;   // bypass: a capture in the transfer cycle goes straight out
        offsOut <= offsNext;
      end
    end
  end

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.capGain |=> $stable(gainCap));  // R9
  AST_OFFS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.capOffs |=> $stable(offsCap));  // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.xfer |=> ($stable(gainOut) && $stable(offsOut)));  // R8
  AST_XFER_FRESH: assert property (@(posedge clk) disable iff (rst)
    stb.xfer |=> (gainOut == gainCap && offsOut == offsCap));  // R10
endmodule

// File: rtl/pix_coef_capture.sv
module pix_coef_capture #(
  parameter int PIX_CYC   = 4,
  parameter int BUS_W     = 10,
  parameter int GAIN_FRAC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgOneBus,
  input  logic             cfgIntClk,
  input  logic             cfgGainEn,
  input  logic [BUS_W-1:0] coefBus,
  input  logic [BUS_W-1:0] pixBus,
  output logic             gainStb,
  output logic             offsStb,
  output logic             pixOe,
  output logic             eoc,
  output logic [BUS_W-1:0] gainOut,
  output logic [BUS_W-1:0] offsOut
);
  pcc_pkg::strobe_t stb;

  pcc_ctrl #(.PIX_CYC(PIX_CYC)) i_ctrl (
    .clk(clk), .rst(rst),
    .cfgOneBus(cfgOneBus), .cfgIntClk(cfgIntClk), .cfgGainEn(cfgGainEn),
    .stb(stb), .gainStb(gainStb), .offsStb(offsStb), .pixOe(pixOe), .eoc(eoc)
  );

  pcc_datapath #(.BUS_W(BUS_W), .GAIN_FRAC(GAIN_FRAC)) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .coefBus(coefBus), .pixBus(pixBus),
    .gainOut(gainOut), .offsOut(offsOut)
  );
endmodule

// File: tb/test_pix_coef_capture.sv
module test_pix_coef_capture;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_CYC    = 2;
  localparam int BUS_W      = 10;
  localparam int GAIN_FRAC  = 8;
  localparam int HALF       = PIX_CYC / 2;
  localparam int UNITY      = 1 << GAIN_FRAC;

  logic clk = 0, rst = 1;
  logic cfgOneBus = 0, cfgIntClk = 1, cfgGainEn = 1;
  logic [BUS_W-1:0] coefBus = '0, pixBus = '0;
  logic gainStb, offsStb, pixOe, eoc;
  logic [BUS_W-1:0] gainOut, offsOut;

  int checks = 0, fails = 0;
  string coefTag = "R5";
  bit finished = 0;

  // behavioural reference state
  int mPhase = 0, mGainCap = UNITY, mOffsCap = 0, mGainOut = UNITY, mOffsOut = 0;

  pix_coef_capture #(.PIX_CYC(PIX_CYC), .BUS_W(BUS_W), .GAIN_FRAC(GAIN_FRAC)) i_pix_coef_capture (
    .clk(clk), .rst(rst), .cfgOneBus(cfgOneBus), .cfgIntClk(cfgIntClk), .cfgGainEn(cfgGainEn),
    .coefBus(coefBus), .pixBus(pixBus), .gainStb(gainStb), .offsStb(offsStb),
    .pixOe(pixOe), .eoc(eoc), .gainOut(gainOut), .offsOut(offsOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update at the active edge
  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mGainCap = UNITY; mOffsCap = 0; mGainOut = UNITY; mOffsOut = 0;
    end else begin
      int src;
      bit capG, capO;
      src  = cfgOneBus ? int'(pixBus) : int'(coefBus);
      capG = cfgIntClk && cfgGainEn && mPhase == 0;
      capO = cfgIntClk && (cfgOneBus ? cfgGainEn : 1'b1) && mPhase == HALF;
      if (capG) mGainCap = src;
      if (capO) mOffsCap = src;
      if (mPhase == PIX_CYC - 1) begin
        mGainOut = mGainCap;
        mOffsOut = mOffsCap;
      end
      mPhase = (mPhase + 1) % PIX_CYC;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2", "eoc", eoc, mPhase == PIX_CYC - 1);
      check("R3", "gainStb", gainStb, cfgIntClk && cfgGainEn && mPhase < HALF);
      check("R4", "offsStb", offsStb, cfgIntClk && !cfgOneBus && mPhase >= HALF);
      check("R7", "pixOe", pixOe,
            !(cfgOneBus && cfgIntClk && cfgGainEn && (mPhase == 0 || mPhase == HALF)));
      check(coefTag, "gainOut", gainOut, mGainOut);                // R8 alignment
      check(coefTag, "offsOut", offsOut, mOffsOut);                // R8 alignment
    end
  end

  task automatic runPhase(input string tag, input bit oneBus, input bit intClk,
                          input bit gainEn, input int cycles);
    @(posedge clk); #1;
    coefTag = tag; cfgOneBus = oneBus; cfgIntClk = intClk; cfgGainEn = gainEn;
    for (int i = 0; i < cycles; i++) begin
      coefBus = BUS_W'($urandom);
      pixBus  = BUS_W'($urandom);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state seen in the first cycle after reset
    check("R1", "gainOut reset", gainOut, UNITY);
    check("R1", "offsOut reset", offsOut, 0);
    check("R1", "eoc at phase 0", eoc, PIX_CYC == 1);
    runPhase("R5", 0, 1, 1, 40);    // two-bus capture from coefBus
    runPhase("R6", 1, 1, 1, 40);    // one-bus capture from pixBus, coefBus ignored
    runPhase("R9", 0, 0, 1, 20);    // strobes off: outputs hold
    runPhase("R9", 1, 1, 0, 20);    // one-bus, gain strobe disabled: nothing captured
    runPhase("R9", 0, 1, 0, 20);    // two-bus, only offset captured
    runPhase("R10", 1, 1, 1, 30);   // offset capture coincides with transfer
    runPhase("R10", 0, 1, 1, 30);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check("R1", "gainOut after mid-run reset", gainOut, UNITY);
    check("R1", "offsOut after mid-run reset", offsOut, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule